// File: doc/BRIEF.md
# Two-Way Lockable Instruction Cache

This block is a read-only instruction cache for one fetch port. It holds 2 KB of instructions in 128 lines of four 32-bit words, arranged as 64 sets of two ways. The cache indexes and tags by physical address. A fetch that misses reads the whole line from a simple memory port as a burst of four beats. The burst starts at word 0. The core gets the word it asked for as soon as that beat arrives. The cache stays busy until the line is complete.

Replacement uses one least-recently-used bit per set. Software can pin single lines so they are never replaced. When both ways of a set are pinned, a miss is still served from memory but nothing is allocated. The same request port also carries three commands, each selected by an operation code: lock a line by address, unlock a line by address, and invalidate the whole cache. The cache takes one request at a time, and every request gets exactly one response pulse.

Top module: `icache_lock2w`

## Requirements
- R1: After reset every line is invalid and unlocked, `req_ready_o` is high, and `rsp_valid_o` and `mem_req_o` are low.
- R2: The byte address splits into byte [1:0] (ignored), word [3:2], set index [9:4] and tag [31:10]. A fetch (op code 0) whose tag matches a valid line in either way of its set returns that word with `rsp_valid_o` high in the second cycle after acceptance, and it makes no memory request.
- R3: On a miss, `mem_req_o` stays high with a stable `mem_addr_o` equal to the line address (bits [3:0] zero) until four beats have been accepted on `mem_rvalid_i`. Beat n carries word n of the line.
- R4: On a miss, the requested word appears on `rsp_data_o` with `rsp_valid_o` in the cycle after its beat is accepted. Each request produces exactly one single-cycle response.
- R5: A fill never goes into a locked way. If both ways are unlocked, an invalid way is taken first (way 0 before way 1). Otherwise the least-recently-used way is taken.
- R6: Each set's LRU state points to the way other than the one most recently hit or filled, counting hits from fetch and lock operations.
- R7: When both ways of the set are locked, a miss is served from memory and nothing is allocated, so repeating the same fetch misses again.
- R8: A lock operation (op code 1) returns the word like a fetch. On a hit it locks the hit way. On a miss it fills the line and then locks the way that was filled.
- R9: An unlock operation (op code 2) clears the lock bit of every way in the set whose stored tag matches, whether the line is valid or not. An unlock that matches no tag changes nothing. The response comes in the second cycle after acceptance, with data 0.
- R10: An invalidate operation (op code 3) clears every valid bit at once and leaves all lock bits as they were. The response comes in the second cycle after acceptance, with data 0.
- R11: `req_ready_o` is high only while the cache is idle. It stays low from acceptance until the response has been given and any line fill has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Cache idle, request accepted this cycle |
| req_op_i | input | 2 | 0 fetch, 1 lock, 2 unlock, 3 invalidate all |
| req_addr_i | input | 32 | Byte address of the request |
| rsp_valid_o | output | 1 | Single-cycle response strobe |
| rsp_data_o | output | 32 | Returned instruction word, 0 for unlock and invalidate |
| mem_req_o | output | 1 | Line burst read in progress |
| mem_addr_o | output | 32 | Line-aligned burst address |
| mem_rvalid_i | input | 1 | Memory beat valid this cycle |
| mem_rdata_i | input | 32 | Memory beat data |

## Verification
Most internal faults appear at the ports within one or two requests to the same set. A wrong LRU bit or victim choice shows up as a memory burst where a hit was due, or as a hit where a miss was due, on the next request to the conflicting tag. A stale valid or lock bit shows up the same way after an invalidate or an unlock. Faults in the beat counter or in capturing the requested word appear in the same request: wrong data, a response in the wrong cycle, or a burst of the wrong length. The bench therefore keeps a requirement-level model of tags, valid bits, locks and LRU. Against that model it checks, for every request, the data, the response cycle and whether a fill took place.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    OP_FETCH  = 2'd0,
    OP_LOCK   = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_INVAL  = 2'd3
  } icache_op_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int SETS  = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [1:0]       hit_o,
  output logic [1:0]       tag_eq_o,
  output logic [1:0]       lock_o,
  output logic [1:0]       valid_o,
  output logic             lru_o,
  input  logic             inval_i,
  input  logic             touch_i,
  input  logic             touch_way_i,
  input  logic             fill_i,
  input  logic             fill_way_i,
  input  logic [1:0]       lock_set_i,
  input  logic [1:0]       lock_clr_i
);

  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  lock_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             sel_fill;

    assign sel_fill = fill_i && (fill_way_i == 1'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
        lock_q  <= '0;
        for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
      end else begin
        if (inval_i)       valid_q        <= '0;
        else if (sel_fill) valid_q[idx_i] <= 1'b1;
        if (sel_fill)      tag_q[idx_i]   <= tag_i;
        if (lock_set_i[w])      lock_q[idx_i] <= 1'b1;
        else if (lock_clr_i[w]) lock_q[idx_i] <= 1'b0;
      end
    end

    assign tag_eq_o[w] = (tag_q[idx_i] == tag_i);
    assign valid_o[w]  = valid_q[idx_i];
    assign lock_o[w]   = lock_q[idx_i];
    assign hit_o[w]    = valid_q[idx_i] && tag_eq_o[w];
  end

  // lru bit names the way to evict next
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q        <= '0;
    else if (touch_i) lru_q[idx_i] <= ~touch_way_i;
  end

  assign lru_o = lru_q[idx_i];

  // R5
  fill_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> !lock_o[fill_way_i]);

  // R10
  inval_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (g_way[0].valid_q == '0 && g_way[1].valid_q == '0));

  // R10
  inval_keep_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> ($stable(g_way[0].lock_q) && $stable(g_way[1].lock_q)));

  // R6
  lru_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (lru_q[$past(idx_i)] != $past(touch_way_i)));

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int SETS       = 64,
  parameter int IDX_W      = 6,
  parameter int LINE_WORDS = 4,
  parameter int WORD_BITS  = 2,
  parameter int DATA_W     = 32
) (
  input  logic                   clk_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [WORD_BITS-1:0]   rd_word_i,
  input  logic [WORD_BITS-1:0]   wr_word_i,
  input  logic                   we_i,
  input  logic                   way_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [1:0][DATA_W-1:0] rdata_o
);

  localparam int DEPTH = SETS * LINE_WORDS;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && (way_i == 1'(w))) mem_q[{idx_i, wr_word_i}] <= wdata_i;
    end

    assign rdata_o[w] = mem_q[{idx_i, rd_word_i}];
  end

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int IDX_W      = 6,
  parameter int TAG_W      = 22,
  parameter int WORD_BITS  = 2,
  parameter int BYTE_BITS  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [1:0]             req_op_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  output logic                   rsp_valid_o,
  output logic [DATA_W-1:0]      rsp_data_o,
  output logic                   mem_req_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  input  logic                   mem_rvalid_i,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic [IDX_W-1:0]       idx_o,
  output logic [TAG_W-1:0]       tag_o,
  output logic [WORD_BITS-1:0]   rd_word_o,
  output logic [WORD_BITS-1:0]   wr_word_o,
  input  logic [1:0]             hit_i,
  input  logic [1:0]             tag_eq_i,
  input  logic [1:0]             lock_i,
  input  logic [1:0]             valid_i,
  input  logic                   lru_i,
  input  logic [1:0][DATA_W-1:0] rdata_i,
  output logic                   inval_o,
  output logic                   touch_o,
  output logic                   touch_way_o,
  output logic                   fill_o,
  output logic                   fill_way_o,
  output logic [1:0]             lock_set_o,
  output logic [1:0]             lock_clr_o,
  output logic                   dwe_o,
  output logic                   dway_o,
  output logic [DATA_W-1:0]      dwdata_o
);

  localparam int OFS_W = WORD_BITS + BYTE_BITS;
  localparam logic [WORD_BITS-1:0] LAST_BEAT = WORD_BITS'(LINE_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL} state_e;

  state_e                 state_q;
  icache_op_e             op_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [WORD_BITS-1:0]   beat_q;
  logic                   alloc_q, vway_q;
  logic                   rsp_valid_q;
  logic [DATA_W-1:0]      rsp_data_q;

  logic                   look_rd, hit_any, hit_way, last_beat, beat_ok;
  logic                   alloc_d, vway_d;
  logic [WORD_BITS-1:0]   word;
  logic                   unused_byte;

  assign idx_o       = addr_q[OFS_W +: IDX_W];
  assign tag_o       = addr_q[ADDR_W-1 -: TAG_W];
  assign word        = addr_q[BYTE_BITS +: WORD_BITS];
  assign unused_byte = ^addr_q[BYTE_BITS-1:0];

  assign hit_any   = |hit_i;
  assign hit_way   = hit_i[1];
  assign look_rd   = (state_q == S_LOOK) && (op_q == OP_FETCH || op_q == OP_LOCK);
  assign beat_ok   = (state_q == S_FILL) && mem_rvalid_i;
  assign last_beat = (beat_q == LAST_BEAT);

  // victim: skip locked ways, prefer invalid, else lru
  always_comb begin
    alloc_d = 1'b1;
    vway_d  = lru_i;
    case (lock_i)
      2'b11:   alloc_d = 1'b0;
      2'b01:   vway_d  = 1'b1;
      2'b10:   vway_d  = 1'b0;
      default: begin
        if (!valid_i[0])      vway_d = 1'b0;
        else if (!valid_i[1]) vway_d = 1'b1;
        else                  vway_d = lru_i;
      end
    endcase
  end

  assign inval_o     = (state_q == S_LOOK) && (op_q == OP_INVAL);
  assign fill_o      = beat_ok && last_beat && alloc_q;
  assign fill_way_o  = vway_q;
  assign touch_o     = (look_rd && hit_any) || fill_o;
  assign touch_way_o = (state_q == S_FILL) ? vway_q : hit_way;
  assign lock_clr_o  = ((state_q == S_LOOK) && (op_q == OP_UNLOCK)) ? tag_eq_i : 2'b00;

  always_comb begin
    lock_set_o = 2'b00;
    if (op_q == OP_LOCK) begin
      if (look_rd && hit_any) lock_set_o = hit_i;
      else if (fill_o)        lock_set_o = vway_q ? 2'b10 : 2'b01;
    end
  end

  assign dwe_o     = beat_ok && alloc_q;
  assign dway_o    = vway_q;
  assign dwdata_o  = mem_rdata_i;
  assign wr_word_o = beat_q;
  assign rd_word_o = word;

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_FILL);
  assign mem_addr_o  = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_FETCH;
      addr_q      <= '0;
      beat_q      <= '0;
      alloc_q     <= 1'b0;
      vway_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid_i) begin
            op_q    <= icache_op_e'(req_op_i);
            addr_q  <= req_addr_i;
            state_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (look_rd && !hit_any) begin
            state_q <= S_FILL;
            beat_q  <= '0;
            alloc_q <= alloc_d;
            vway_q  <= vway_d;
          end else begin
            state_q     <= S_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= look_rd ? rdata_i[hit_way] : '0;
          end
        end
        S_FILL: begin
          if (mem_rvalid_i) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == word) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= mem_rdata_i;
            end
            if (last_beat) state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);

  // R3
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R3
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_req_o) |-> $past(mem_rvalid_i));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/icache_lock2w.sv
module icache_lock2w
  import icache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 2048,
  parameter int LINE_WORDS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int LINE_BYTES = WORD_BYTES * LINE_WORDS;
  localparam int SETS       = CACHE_BYTES / (LINE_BYTES * 2);
  localparam int BYTE_BITS  = $clog2(WORD_BYTES);
  localparam int WORD_BITS  = $clog2(LINE_WORDS);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - IDX_W - WORD_BITS - BYTE_BITS;

  logic [IDX_W-1:0]       idx;
  logic [TAG_W-1:0]       tag;
  logic [WORD_BITS-1:0]   rd_word, wr_word;
  logic [1:0]             hit, tag_eq, lock, valid, lock_set, lock_clr;
  logic                   lru, inval, touch, touch_way, fill, fill_way;
  logic                   dwe, dway;
  logic [DATA_W-1:0]      dwdata;
  logic [1:0][DATA_W-1:0] rdata;

  icache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .IDX_W(IDX_W),
    .TAG_W(TAG_W), .WORD_BITS(WORD_BITS), .BYTE_BITS(BYTE_BITS)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i,
    .rsp_valid_o, .rsp_data_o, .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .idx_o(idx), .tag_o(tag), .rd_word_o(rd_word), .wr_word_o(wr_word),
    .hit_i(hit), .tag_eq_i(tag_eq), .lock_i(lock), .valid_i(valid), .lru_i(lru),
    .rdata_i(rdata), .inval_o(inval), .touch_o(touch), .touch_way_o(touch_way),
    .fill_o(fill), .fill_way_o(fill_way), .lock_set_o(lock_set), .lock_clr_o(lock_clr),
    .dwe_o(dwe), .dway_o(dway), .dwdata_o(dwdata)
  );

  icache_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni, .idx_i(idx), .tag_i(tag), .hit_o(hit), .tag_eq_o(tag_eq),
    .lock_o(lock), .valid_o(valid), .lru_o(lru), .inval_i(inval), .touch_i(touch),
    .touch_way_i(touch_way), .fill_i(fill), .fill_way_i(fill_way),
    .lock_set_i(lock_set), .lock_clr_i(lock_clr)
  );

  icache_data_store #(
    .SETS(SETS), .IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS), .WORD_BITS(WORD_BITS), .DATA_W(DATA_W)
  ) u_data (
    .clk_i, .idx_i(idx), .rd_word_i(rd_word), .wr_word_i(wr_word), .we_i(dwe),
    .way_i(dway), .wdata_i(dwdata), .rdata_o(rdata)
  );

endmodule

// File: tb/tb_icache_lock2w.sv
`timescale 1ns/1ps
module tb_icache_lock2w;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_op_i = 2'd0;
  logic [31:0] req_addr_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  icache_lock2w dut (.*);

  // reference state, from the requirements
  bit          m_valid [2][64];
  bit          m_lock  [2][64];
  logic [21:0] m_tag   [2][64];
  bit          m_lru   [64];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mk(input int tg, input int st, input int wd);
    return {22'(tg), 6'(st), 2'(wd), 2'b00};
  endfunction

  // memory model
  int          beat_cnt = 0;
  int          fill_cnt = 0;
  bit          prev_beat_hit = 0;
  int          prev_beat_idx = 0;
  logic        req_d = 1'b0;
  logic [31:0] last_fill_addr = '0;

  always @(posedge clk_i) begin
    prev_beat_hit <= mem_req_o && mem_rvalid_i;
    prev_beat_idx <= beat_cnt;
    if (mem_req_o && mem_rvalid_i) beat_cnt <= beat_cnt + 1;
    else if (!mem_req_o)           beat_cnt <= 0;
    req_d <= mem_req_o;
    if (mem_req_o && !req_d) begin
      fill_cnt       <= fill_cnt + 1;
      last_fill_addr <= mem_addr_o;
    end
  end

  always @(negedge clk_i) begin
    mem_rvalid_i = mem_req_o && (beat_cnt < 4) && (($urandom % 4) != 0);
    mem_rdata_i  = mem_rvalid_i ? mem_word(mem_addr_o + 32'(4 * beat_cnt)) : '0;
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [31:0] addr, input string rq);
    int          s = int'(addr[9:4]);
    logic [21:0] tg = addr[31:10];
    int          wd = int'(addr[3:2]);
    int          hw = -1;
    int          vw = 0;
    bit          alloc = 1;
    bit          exp_fill = 0;
    logic [31:0] exp_data = '0;
    int          f0, n, got, rn;
    bit          bok;
    logic [31:0] rdata;

    for (int w = 0; w < 2; w++) if (m_valid[w][s] && m_tag[w][s] == tg) hw = w;
    case (op)
      2'd3: for (int w = 0; w < 2; w++) for (int k = 0; k < 64; k++) m_valid[w][k] = 0;
      2'd2: for (int w = 0; w < 2; w++) if (m_tag[w][s] == tg) m_lock[w][s] = 0;
      default: begin
        exp_data = mem_word({addr[31:2], 2'b00});
        if (hw >= 0) begin
          m_lru[s] = (hw == 0);
          if (op == 2'd1) m_lock[hw][s] = 1;
        end else begin
          exp_fill = 1;
          if (m_lock[0][s] && m_lock[1][s]) alloc = 0;
          else if (m_lock[0][s])            vw = 1;
          else if (m_lock[1][s])            vw = 0;
          else if (!m_valid[0][s])          vw = 0;
          else if (!m_valid[1][s])          vw = 1;
          else                              vw = int'(m_lru[s]);
          if (alloc) begin
            m_valid[vw][s] = 1;
            m_tag[vw][s]   = tg;
            m_lru[s]       = (vw == 0);
            if (op == 2'd1) m_lock[vw][s] = 1;
          end
        end
      end
    endcase

    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    f0 = fill_cnt;
    req_valid_i = 1'b1;
    req_op_i    = op;
    req_addr_i  = addr;
    n = 0; got = 0; rn = 0; bok = 0; rdata = '0;
    do begin
      @(negedge clk_i);
      n++;
      req_valid_i = 1'b0;
      if (n == 1) check(!req_ready_o, {rq, " R11"}, "ready while busy", 32'(req_ready_o), 0);
      if (rsp_valid_o) begin
        got++;
        rdata = rsp_data_o;
        rn    = n;
        bok   = prev_beat_hit && (prev_beat_idx == wd);
      end
    end while (!(got > 0 && req_ready_o) && n < 300);

    check(got == 1, {rq, " R4"}, "response count", 32'(got), 1);
    check(rdata == exp_data, {rq, " R2"}, "data", rdata, exp_data);
    check((fill_cnt - f0) == int'(exp_fill), {rq, " R5"}, "fill count", 32'(fill_cnt - f0), 32'(exp_fill));
    if (exp_fill) begin
      check(last_fill_addr == {addr[31:4], 4'b0}, {rq, " R3"}, "burst address",
            last_fill_addr, {addr[31:4], 4'b0});
      check(bok, {rq, " R4"}, "early word timing", 32'(prev_beat_idx), 32'(wd));
    end else begin
      check(rn == 2, {rq, " R2"}, "response cycle", 32'(rn), 2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 64; k++) begin
        m_valid[w][k] = 0; m_lock[w][k] = 0; m_tag[w][k] = '0; m_lru[k] = 0;
      end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(req_ready_o == 1'b1, "R1", "ready after reset", 32'(req_ready_o), 1);
    check(rsp_valid_o == 1'b0, "R1", "rsp after reset", 32'(rsp_valid_o), 0);
    check(mem_req_o == 1'b0, "R1", "mem_req after reset", 32'(mem_req_o), 0);

    // R1 R3 R4 basic miss then hit, byte offset ignored
    do_req(2'd0, mk(7, 5, 2), "R1");
    do_req(2'd0, mk(7, 5, 1) | 32'h3, "R2");
    // R5 R6 LRU sequence
    do_req(2'd0, mk(8, 5, 3), "R5");
    do_req(2'd0, mk(7, 5, 0), "R6");
    do_req(2'd0, mk(8, 5, 0), "R6");
    do_req(2'd0, mk(9, 5, 1), "R6");
    do_req(2'd0, mk(8, 5, 2), "R6");
    do_req(2'd0, mk(7, 5, 3), "R6");
    do_req(2'd0, mk(8, 5, 1), "R6");
    // R8 lock on miss, survives conflicts
    do_req(2'd1, mk(20, 9, 2), "R8");
    do_req(2'd0, mk(21, 9, 0), "R5");
    do_req(2'd0, mk(22, 9, 0), "R5");
    do_req(2'd0, mk(23, 9, 0), "R5");
    do_req(2'd0, mk(20, 9, 3), "R8");
    // R8 lock on hit, R7 no allocation
    do_req(2'd1, mk(23, 9, 1), "R8");
    do_req(2'd0, mk(24, 9, 0), "R7");
    do_req(2'd0, mk(24, 9, 0), "R7");
    // R9 non-matching unlock, then matching
    do_req(2'd2, mk(30, 9, 0), "R9");
    do_req(2'd0, mk(24, 9, 2), "R9");
    do_req(2'd2, mk(23, 9, 0), "R9");
    do_req(2'd0, mk(24, 9, 2), "R9");
    do_req(2'd0, mk(24, 9, 1), "R9");
    // R10 invalidate keeps locks
    do_req(2'd1, mk(40, 12, 0), "R10");
    do_req(2'd3, mk(0, 0, 0), "R10");
    do_req(2'd0, mk(8, 5, 1), "R10");
    do_req(2'd0, mk(40, 12, 0), "R10");
    do_req(2'd0, mk(41, 12, 0), "R10");
    do_req(2'd0, mk(40, 12, 1), "R10");
    do_req(2'd2, mk(40, 12, 0), "R9");
    do_req(2'd0, mk(42, 12, 0), "R9");

    // constrained random mix
    for (int i = 0; i < 2000; i++) begin
      int          r = int'($urandom % 100);
      int          st;
      logic [1:0]  op;
      logic [31:0] a;
      case ($urandom % 4)
        0: st = 3; 1: st = 17; 2: st = 40; default: st = 63;
      endcase
      a = mk(100 + int'($urandom % 4), st, int'($urandom % 4)) | 32'($urandom % 4);
      if (r < 78)      op = 2'd0;
      else if (r < 88) op = 2'd1;
      else if (r < 97) op = 2'd2;
      else             op = 2'd3;
      do_req(op, a, "RND");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule